// File: doc/BRIEF.md
# Power-on reset sequencer

This block converts one external power-on reset line into three internal resets that release in a fixed order: internal power-on reset, then hard reset, then soft reset. The external line is first qualified, so that it only counts once it has been held high for a minimum number of clock cycles. When a qualified reset ends, the internal power-on reset is stretched by a fixed count. The block then waits for a PLL lock indication. After lock it counts a hard-reset delay, which is longer when the DLL is in use and also requires the DLL lock. The soft reset follows a short fixed gap after the hard reset.

Several strap inputs are captured while the sequence runs. At the clock edge where a qualified external reset deasserts, the block latches the configuration master/slave select, the host port enable and the boot mode. At the edge where PLL lock is taken, it latches the debug-entry strap and the DLL-use setting. A reserved boot code is replaced by external-memory boot and raises a sticky error flag. The whole block runs on a single clock, and the analog lock behaviour is represented by the two lock inputs.

Top module: `por_seq_top`

## Requirements
- R1: An external reset pulse counts only if `ext_por` is sampled high on at least MIN_PULSE (16) consecutive rising clock edges. A shorter pulse changes no output at any point in the sequence.
- R2: `por_int_o` deasserts POR_STRETCH (1024) clock edges after the first edge at which a qualified `ext_por` is sampled low. That first low edge is counted as edge 0.
- R3: `pll_lock` is ignored while `por_int_o` is asserted. When the DLL is not used, `hreset_o` deasserts HR_NODLL (512) edges after the edge that takes the lock.
- R4: When `dll_en` is high at the lock edge, `hreset_o` deasserts no earlier than HR_DLL (3585) edges after lock, and only at an edge where `dll_lock` is high.
- R5: `sreset_o` deasserts exactly SR_GAP (3) edges after `hreset_o`. No reset is released before the reset that precedes it in the order internal power-on reset, hard reset, soft reset.
- R6: At the qualified deassertion edge, the block latches `cfg_strap` to `cfg_slave_o` (0 = configuration master, 1 = slave), `host_strap` to `host_en_o` (1 = host port on with 32-bit bus, 0 = hardware reset configuration) and `boot_strap` to `boot_mode_o` (00 = external memory, 01 = host interface).
- R7: Changes on the strap inputs after that edge have no effect on the latched outputs until the next qualified release.
- R8: `dbg_strap` is sampled at the PLL lock edge. `dbg_req_o` goes high together with the release of `sreset_o` if that sample was 1, and stays low otherwise.
- R9: A reserved boot code (10 or 11) yields `boot_mode_o` = 00 and sets `boot_err_o`. The flag holds until the next qualified external reset.
- R10: Once an external reset has been sampled high for the MIN_PULSE-th edge, all three resets are asserted after that edge and `dbg_req_o` is low, whatever the current stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all counting |
| ext_por | input | 1 | External power-on reset, active high |
| pll_lock | input | 1 | PLL lock indication |
| dll_lock | input | 1 | DLL lock indication |
| dll_en | input | 1 | DLL in use, taken at PLL lock |
| cfg_strap | input | 1 | Configuration master/slave strap |
| host_strap | input | 1 | Host port enable strap |
| boot_strap | input | 2 | Boot mode strap |
| dbg_strap | input | 1 | Debug entry strap |
| por_int_o | output | 1 | Internal power-on reset, active high |
| hreset_o | output | 1 | Hard reset, active high |
| sreset_o | output | 1 | Soft reset, active high |
| cfg_slave_o | output | 1 | Latched configuration slave select |
| host_en_o | output | 1 | Latched host port enable |
| boot_mode_o | output | 2 | Latched boot mode, never reserved |
| boot_err_o | output | 1 | Sticky reserved boot code flag |
| dbg_req_o | output | 1 | Debug mode request after reset |

## Verification
An off-by-one in the stretch counter or the hard-reset counter appears as a reset edge one clock early or late. That error is visible the moment the release happens, so the bench measures each release to the exact edge. A stage that fails to honour the DLL lock releases hard reset while `dll_lock` is low, which shows up within one cycle of the count expiring. A badly gated qualifier, or strap latches that stay open, only shows after a later stimulus. Such errors appear as resets that assert on a short glitch, or as configuration outputs that follow strap changes in the cycle after those changes.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_STRETCH = 3'd1,
        ST_PLL     = 3'd2,
        ST_HRWAIT  = 3'd3,
        ST_SRWAIT  = 3'd4,
        ST_RUN     = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic       slave;
        logic       host_en;
        logic [1:0] boot;
        logic       boot_err;
    } strap_cfg_t;

    localparam logic [1:0] BOOT_EXTMEM = 2'b00;
    localparam logic [1:0] BOOT_HOST   = 2'b01;

endpackage

// File: rtl/por_width_qual.sv
module por_width_qual #(
    parameter int MIN_PULSE = 16
) (
    input  logic clk,
    input  logic ext_por,
    output logic kill_o,
    output logic release_o
);
    localparam int CW = $clog2(MIN_PULSE + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } qual_t;

    qual_t q_q, q_d;

    always_comb begin
        q_d = q_q;
        if (ext_por) begin
            if (q_q.cnt != CW'(MIN_PULSE))
                q_d.cnt = q_q.cnt + 1'b1;
        end else begin
            q_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        q_q <= q_d;
    end

    assign kill_o    = ext_por && (q_q.cnt >= CW'(MIN_PULSE - 1));
    assign release_o = !ext_por && (q_q.cnt == CW'(MIN_PULSE));

    // R1: a release is only possible right after a qualified assertion
    a_r1_release_needs_kill: assert property (@(posedge clk) disable iff (ext_por)
        release_o |-> $past(kill_o));

endmodule

// File: rtl/por_cfg_latch.sv
module por_cfg_latch
    import por_seq_pkg::*;
(
    input  logic       clk,
    input  logic       kill_i,
    input  logic       release_i,
    input  logic       cfg_strap,
    input  logic       host_strap,
    input  logic [1:0] boot_strap,
    output strap_cfg_t cfg_o
);
    strap_cfg_t cfg_q, cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (kill_i)
            cfg_d.boot_err = 1'b0;
        if (release_i) begin
            cfg_d.slave   = cfg_strap;
            cfg_d.host_en = host_strap;
            if (boot_strap[1]) begin
                cfg_d.boot     = BOOT_EXTMEM;
                cfg_d.boot_err = 1'b1;
            end else begin
                cfg_d.boot = boot_strap;
            end
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R7: latched straps move only at a release edge
    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (kill_i)
        !release_i |=> $stable({cfg_q.slave, cfg_q.host_en, cfg_q.boot}));

    // R9: the reserved-code flag holds until a qualified reset
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (kill_i)
        cfg_q.boot_err |=> cfg_q.boot_err);

endmodule

// File: rtl/por_seq_top.sv
module por_seq_top
    import por_seq_pkg::*;
#(
    parameter int MIN_PULSE   = 16,
    parameter int POR_STRETCH = 1024,
    parameter int HR_DLL      = 3585,
    parameter int HR_NODLL    = 512,
    parameter int SR_GAP      = 3
) (
    input  logic       clk,
    input  logic       ext_por,
    input  logic       pll_lock,
    input  logic       dll_lock,
    input  logic       dll_en,
    input  logic       cfg_strap,
    input  logic       host_strap,
    input  logic [1:0] boot_strap,
    input  logic       dbg_strap,
    output logic       por_int_o,
    output logic       hreset_o,
    output logic       sreset_o,
    output logic       cfg_slave_o,
    output logic       host_en_o,
    output logic [1:0] boot_mode_o,
    output logic       boot_err_o,
    output logic       dbg_req_o
);
    localparam int CNT_MAX = (POR_STRETCH > HR_DLL)
                           ? ((POR_STRETCH > HR_NODLL) ? POR_STRETCH : HR_NODLL)
                           : ((HR_DLL > HR_NODLL) ? HR_DLL : HR_NODLL);
    localparam int CW = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic          dll_use;
        logic          dbg;
    } seq_t;

    seq_t       s_q, s_d;
    logic       kill, rel;
    strap_cfg_t cfg;
    logic [CW-1:0] hr_lim;

    por_width_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
        .clk       (clk),
        .ext_por   (ext_por),
        .kill_o    (kill),
        .release_o (rel)
    );

    por_cfg_latch u_cfg (
        .clk        (clk),
        .kill_i     (kill),
        .release_i  (rel),
        .cfg_strap  (cfg_strap),
        .host_strap (host_strap),
        .boot_strap (boot_strap),
        .cfg_o      (cfg)
    );

    assign hr_lim = s_q.dll_use ? CW'(HR_DLL) : CW'(HR_NODLL);

    always_comb begin
        s_d = s_q;
        case (s_q.state)
            ST_IDLE: begin
                if (rel) begin
                    s_d.state = ST_STRETCH;
                    s_d.cnt   = '0;
                end
            end
            ST_STRETCH: begin
                if (s_q.cnt == CW'(POR_STRETCH - 1)) begin
                    s_d.state = ST_PLL;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_PLL: begin
                if (pll_lock) begin
                    s_d.state   = ST_HRWAIT;
                    s_d.cnt     = '0;
                    s_d.dll_use = dll_en;
                    s_d.dbg     = dbg_strap;
                end
            end
            ST_HRWAIT: begin
                if (s_q.cnt >= hr_lim - 1'b1) begin
                    if (!s_q.dll_use || dll_lock) begin
                        s_d.state = ST_SRWAIT;
                        s_d.cnt   = '0;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_SRWAIT: begin
                if (s_q.cnt == CW'(SR_GAP - 1)) begin
                    s_d.state = ST_RUN;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_RUN: ;
            default: s_d.state = ST_IDLE;
        endcase
        if (kill) begin
            s_d.state   = ST_IDLE;
            s_d.cnt     = '0;
            s_d.dll_use = 1'b0;
            s_d.dbg     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign por_int_o   = (s_q.state == ST_IDLE) || (s_q.state == ST_STRETCH);
    assign hreset_o    = (s_q.state != ST_SRWAIT) && (s_q.state != ST_RUN);
    assign sreset_o    = (s_q.state != ST_RUN);
    assign dbg_req_o   = (s_q.state == ST_RUN) && s_q.dbg;
    assign cfg_slave_o = cfg.slave;
    assign host_en_o   = cfg.host_en;
    assign boot_mode_o = cfg.boot;
    assign boot_err_o  = cfg.boot_err;

    // R5: soft reset follows hard reset by the fixed gap
    a_r5_sr_gap: assert property (@(posedge clk) disable iff (ext_por)
        $fell(sreset_o) |-> ($past(hreset_o, 4) && !$past(hreset_o, 3)));

    // R5: release order
    a_r5_sr_after_hr: assert property (@(posedge clk) disable iff (ext_por)
        !sreset_o |-> !hreset_o);
    a_r5_hr_after_por: assert property (@(posedge clk) disable iff (ext_por)
        !hreset_o |-> !por_int_o);

    // R4: with the DLL in use, hard reset leaves only with DLL lock present
    a_r4_dll_gate: assert property (@(posedge clk) disable iff (ext_por)
        (s_q.state == ST_HRWAIT && s_q.dll_use && !dll_lock) |=> hreset_o);

    // R8: debug request only once running
    a_r8_dbg_running: assert property (@(posedge clk) disable iff (ext_por)
        dbg_req_o |-> !sreset_o);

endmodule

// File: tb/sim_por_seq_top.sv
module sim_por_seq_top;
    localparam int POR_STRETCH = 1024;
    localparam int HR_DLL      = 3585;
    localparam int HR_NODLL    = 512;

    logic clk = 1'b0;
    logic ext_por = 1'b0, pll_lock = 1'b0, dll_lock = 1'b0, dll_en = 1'b0;
    logic cfg_strap = 1'b0, host_strap = 1'b0, dbg_strap = 1'b0;
    logic [1:0] boot_strap = 2'b00;
    logic por_int_o, hreset_o, sreset_o, cfg_slave_o, host_en_o, boot_err_o, dbg_req_o;
    logic [1:0] boot_mode_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    por_seq_top u0 (
        .clk(clk), .ext_por(ext_por), .pll_lock(pll_lock), .dll_lock(dll_lock),
        .dll_en(dll_en), .cfg_strap(cfg_strap), .host_strap(host_strap),
        .boot_strap(boot_strap), .dbg_strap(dbg_strap), .por_int_o(por_int_o),
        .hreset_o(hreset_o), .sreset_o(sreset_o), .cfg_slave_o(cfg_slave_o),
        .host_en_o(host_en_o), .boot_mode_o(boot_mode_o), .boot_err_o(boot_err_o),
        .dbg_req_o(dbg_req_o)
    );

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ext_por high for w rising edges, lowered at a falling edge
    task automatic pulse(int w);
        @(negedge clk) ext_por = 1'b1;
        repeat (w) @(negedge clk);
        ext_por = 1'b0;
    endtask

    task automatic cnt_por(output int n);
        n = 0;
        while (por_int_o && n < 20000) begin @(negedge clk); n++; end
    endtask
    task automatic cnt_hr(output int n);
        n = 0;
        while (hreset_o && n < 20000) begin @(negedge clk); n++; end
    endtask
    task automatic cnt_sr(output int n);
        n = 0;
        while (sreset_o && n < 20000) begin @(negedge clk); n++; end
    endtask

    // full sequence with straps, lock supplied after internal POR release
    task automatic run_seq(bit dll, bit c, bit h, bit [1:0] b, bit dbg);
        int n;
        cfg_strap = c; host_strap = h; boot_strap = b;
        pulse(20);
        @(negedge clk);
        cfg_strap = ~c; host_strap = ~h; boot_strap = ~b;  // R7 stimulus
        cnt_por(n);
        chk("R2", n + 1, POR_STRETCH + 1, "internal POR release edge");
        pll_lock = 1'b1; dll_en = dll; dll_lock = dll; dbg_strap = dbg;
        @(negedge clk) dbg_strap = ~dbg;
        cnt_hr(n);
        chk(dll ? "R4" : "R3", n + 1, (dll ? HR_DLL : HR_NODLL) + 1, "hard reset release edge");
        chk("R8", dbg_req_o, 0, "no debug request while soft reset held");
        cnt_sr(n);
        chk("R5", n, 3, "soft reset gap");
        chk("R8", dbg_req_o, dbg, "debug request");
        chk("R6", cfg_slave_o, c, "slave select");
        chk("R6", host_en_o, h, "host enable");
        chk("R7", boot_mode_o, b[1] ? 0 : b, "boot mode after strap change");
        chk("R9", boot_err_o, b[1], "reserved flag");
        pll_lock = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk); @(negedge clk);
        pulse(20);
        ext_por = 1'b1;  // still held for the check
        @(negedge clk);
        chk("R10", {por_int_o, hreset_o, sreset_o}, 7, "resets while held");
        chk("R10", dbg_req_o, 0, "debug request while held");
        ext_por = 1'b0;
    endtask

    task automatic t_dll_wait();
        int n;
        pulse(20);
        cnt_por(n);
        pll_lock = 1'b1; dll_en = 1'b1; dll_lock = 1'b0; dbg_strap = 1'b0;
        repeat (HR_DLL + 20) @(negedge clk);
        chk("R4", hreset_o, 1, "hard reset held without DLL lock");
        dll_lock = 1'b1;
        @(negedge clk);
        chk("R4", hreset_o, 0, "hard reset after DLL lock");
        cnt_sr(n);
        chk("R5", n, 3, "soft reset gap after DLL wait");
        pll_lock = 1'b0; dll_en = 1'b0; dll_lock = 1'b0;
    endtask

    task automatic t_early_lock();
        int n;
        pll_lock = 1'b1; dll_en = 1'b0;
        pulse(20);
        cnt_hr(n);
        chk("R3", n, POR_STRETCH + HR_NODLL + 2, "lock held during internal POR");
        cnt_sr(n);
        pll_lock = 1'b0;
    endtask

    task automatic t_short_and_kill();
        // running now; a 15-edge pulse must be ignored
        pulse(15);
        repeat (30) @(negedge clk);
        chk("R1", sreset_o, 0, "short pulse ignored");
        chk("R9", boot_err_o, 1, "flag survives short pulse");
        chk("R1", boot_mode_o, 0, "boot mode kept after short pulse");
        @(negedge clk) ext_por = 1'b1;
        repeat (15) @(negedge clk);
        chk("R10", sreset_o, 0, "still running after 15 edges");
        @(negedge clk);
        chk("R10", {por_int_o, hreset_o, sreset_o}, 7, "all resets after 16th edge");
        chk("R9", boot_err_o, 0, "flag cleared by qualified reset");
        repeat (4) @(negedge clk);
        ext_por = 1'b0;
    endtask

    initial begin
        t_reset_state();
        run_seq(1'b0, 1'b1, 1'b0, 2'b01, 1'b0);
        run_seq(1'b1, 1'b0, 1'b1, 2'b00, 1'b1);
        t_dll_wait();
        t_early_lock();
        run_seq(1'b0, 1'b1, 1'b1, 2'b10, 1'b0);
        t_short_and_kill();
        run_seq(1'b0, 1'b0, 1'b0, 2'b11, 1'b1);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule